// File: doc/BRIEF.md
# Breakpoint Combiner and Instruction Step Counter

This block sits in an on-chip debug path. It turns two breakpoint match strobes, produced by address comparators outside the block, into a single trigger. Software picks how the two are joined: either one alone, both in the same cycle, or a first-then-second ordering. A step counter lets the core run a programmed number of instructions at full speed before a request stops it. The counter counts one per instruction-retired strobe.

The counter can be started by a count write. It can also be held until the combined trigger fires, which gives "run N more instructions after the breakpoint hits" scenarios. Whichever event occurs, the action is a one-cycle pulse on either the debug-entry request or the interrupt request, chosen by a control bit. After that pulse the unit stays quiet until software rewrites the control register.

Software reaches the block through a small write port. Address 0 is the control register, with these fields:
- bits [1:0]: combine mode (00 off, 01 either, 10 both, 11 ordered).
- bit 2: action (0 selects debug entry, 1 selects interrupt).
- bit 3: counter start source (0 starts on a count write, 1 starts when the trigger fires).

Address 1 holds the 24-bit step count.

Top module: `bkpt_step_trigger`

## Requirements
- R1: After reset both request outputs are low and the combine mode is off, so match strobes produce no request until the control register is written.
- R2: In "either" mode (control bits [1:0] = 01), a match on A or on B produces a request one clock after the match cycle.
- R3: In "both" mode (bits [1:0] = 10), a request follows only when A and B are high in the same cycle; either one alone produces nothing.
- R4: In "ordered" mode (bits [1:0] = 11), A arms the unit and a later B fires. B while unarmed does nothing. A and B together while unarmed only arm the unit. B on any later cycle then fires.
- R5: A control register write clears the ordered-mode armed state, so an A before that write does not let a B after it fire.
- R6: With control bit 3 = 0, writing a nonzero count N to address 1 starts the counter. The request follows one clock after the Nth retire strobe. A count of 0 never starts it.
- R7: The counter advances only on cycles with the retire strobe high. A count of 1 gives a single step: a request after the first retire.
- R8: With control bit 3 = 1, the count written to address 1 is held. The combined trigger then loads it and starts counting instead of raising a request. The retire strobe in the trigger cycle is not counted, and retires before the trigger are ignored.
- R9: Control bit 2 selects the output. When it is 0, the request appears on the debug-entry output; when it is 1, it appears on the interrupt output. Each request is one clock high, and the other output stays low.
- R10: After a request the unit ignores matches, retires and count writes until the control register is written again.
- R11: In a cycle where the write port is active, match strobes and the retire strobe are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| match_a | input | 1 | First breakpoint match strobe |
| match_b | input | 1 | Second breakpoint match strobe |
| retire | input | 1 | One instruction retired this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control, 1 = step count |
| wr_data | input | CNT_W | Write data |
| dbg_req | output | 1 | One-cycle debug-entry request |
| irq_req | output | 1 | One-cycle interrupt request |

## Verification
The bench drives A and B together while the unit is unarmed in ordered mode; a design that fires there would stop the core a breakpoint early. It checks that counts of 1 and 0 behave as a single step and as a no-op, and that idle cycles between retires are not counted. Off-by-one or free-running counters show up as early or late requests. It also checks that a retire coinciding with the trigger is dropped in trigger-start mode, and that a second match or a fresh count write after a request stays silent. A design without the lockout would pulse twice.

// File: rtl/bkpt_step_trigger.sv
`timescale 1ns/1ps
module bkpt_step_trigger #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             match_a,
  input  logic             match_b,
  input  logic             retire,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             dbg_req,
  output logic             irq_req
);
  localparam logic [1:0] M_OFF = 2'd0, M_OR = 2'd1, M_AND = 2'd2, M_SEQ = 2'd3;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [1:0]       mode;
  logic             act_irq, on_trig;
  logic             armed, spent, running;
  logic [CNT_W-1:0] cnt, reload;
  logic             hit, live, trig, arm_set, expire, act;

  wire wr_ctl = wr_en && !wr_addr;
  wire wr_cnt = wr_en &&  wr_addr;

  always_comb begin
    case (mode)
      M_OR:    hit = match_a || match_b;
      M_AND:   hit = match_a && match_b;
      M_SEQ:   hit = armed && match_b;
      default: hit = 1'b0;
    endcase
  end

  assign live    = !wr_en && !spent && (mode != M_OFF) && !(on_trig && running);
  assign trig    = live && hit;
  assign arm_set = live && (mode == M_SEQ) && !armed && match_a;
  assign expire  = !wr_en && running && retire && (cnt == ONE);
  assign act     = (trig && !on_trig) || expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_OFF; act_irq <= 1'b0; on_trig <= 1'b0;
      armed <= 1'b0; spent <= 1'b0; running <= 1'b0;
      cnt <= '0; reload <= '0;
    end else if (wr_ctl) begin
      mode    <= wr_data[1:0];
      act_irq <= wr_data[2];
      on_trig <= wr_data[3];
      armed   <= 1'b0;
      spent   <= 1'b0;
      running <= 1'b0;
      cnt     <= '0;
    end else if (wr_cnt) begin
      reload <= wr_data;
      if (!on_trig) begin
        cnt     <= wr_data;
        running <= !spent && (wr_data != '0);
      end
    end else begin
      if (trig && on_trig) begin
        cnt     <= reload;
        running <= (reload != '0);
      end else if (running && retire) begin
        cnt <= cnt - ONE;
      end
      if (trig)         armed <= 1'b0;
      else if (arm_set) armed <= 1'b1;
      if (act) begin
        spent   <= 1'b1;
        running <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_req <= 1'b0;
      irq_req <= 1'b0;
    end else begin
      dbg_req <= act && !act_irq;
      irq_req <= act &&  act_irq;
    end
  end

  assert_one_shot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req || irq_req) |=> !(dbg_req || irq_req));

  assert_spent_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    spent |=> !(dbg_req || irq_req));

  assert_count_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && retire && !wr_en && cnt > ONE) |=> (cnt == $past(cnt) - ONE));

  assert_expire_fires_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && retire && !wr_en && cnt == ONE) |=> (dbg_req || irq_req));

  assert_seq_needs_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SEQ && !armed && !running) |=> !(dbg_req || irq_req));

  assert_ctl_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (!armed && !running && !spent));

  assert_write_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !(dbg_req || irq_req));
endmodule

// File: tb/bkpt_step_trigger_tb_top.sv
`timescale 1ns/1ps
module bkpt_step_trigger_tb_top;
  localparam int CNT_W = 24;
  logic clk = 1'b0, rst_n = 1'b0;
  logic a = 0, b = 0, r = 0, we = 0, wa = 0;
  logic [CNT_W-1:0] wd = '0;
  logic dbg_req, irq_req;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bkpt_step_trigger #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .match_a(a), .match_b(b), .retire(r),
    .wr_en(we), .wr_addr(wa), .wr_data(wd), .dbg_req(dbg_req), .irq_req(irq_req));

  task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: {dbg,irq} actual=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input logic ma, input logic mb, input logic rt,
                      input string req, input logic [1:0] exp);
    a = ma; b = mb; r = rt;
    @(posedge clk); @(negedge clk);
    a = 0; b = 0; r = 0;
    chk(req, {dbg_req, irq_req}, exp);
  endtask

  task automatic wr(input logic addr, input logic [CNT_W-1:0] d, input logic ma = 0, input logic rt = 0);
    we = 1; wa = addr; wd = d; a = ma; b = ma; r = rt;
    @(posedge clk); @(negedge clk);
    we = 0; a = 0; b = 0; r = 0;
  endtask

  task automatic t_reset;
    chk("R1 reset", {dbg_req, irq_req}, 2'b00);
    step(1, 1, 1, "R1 off after reset", 2'b00);
  endtask

  task automatic t_or;
    wr(0, 24'h1);
    step(1, 0, 0, "R2 A alone", 2'b10);
    step(0, 0, 0, "R9 one cycle", 2'b00);
    step(0, 1, 0, "R10 locked", 2'b00);
    wr(0, 24'h1);
    step(0, 1, 0, "R2 B alone", 2'b10);
  endtask

  task automatic t_and;
    wr(0, 24'h2);
    step(1, 0, 0, "R3 A only", 2'b00);
    step(0, 1, 0, "R3 B only", 2'b00);
    step(1, 1, 0, "R3 both", 2'b10);
  endtask

  task automatic t_seq;
    wr(0, 24'h3);
    step(0, 1, 0, "R4 B unarmed", 2'b00);
    step(1, 1, 0, "R4 A+B unarmed arms only", 2'b00);
    step(0, 0, 0, "R4 idle", 2'b00);
    step(0, 1, 0, "R4 B after arm", 2'b10);
    wr(0, 24'h3);
    step(1, 0, 0, "R5 arm", 2'b00);
    wr(0, 24'h3);
    step(0, 1, 0, "R5 arm cleared", 2'b00);
    step(1, 0, 0, "R5 rearm", 2'b00);
    step(0, 1, 0, "R5 fire", 2'b10);
  endtask

  task automatic t_count;
    wr(0, 24'h4);
    wr(1, 24'd3);
    step(0, 0, 1, "R6 retire 1", 2'b00);
    step(0, 0, 1, "R6 retire 2", 2'b00);
    step(0, 0, 1, "R6 R9 retire 3 irq", 2'b01);
    wr(1, 24'd1);
    step(0, 0, 1, "R10 count write ignored", 2'b00);
    wr(0, 24'h4);
    wr(1, 24'd1);
    step(0, 0, 1, "R7 single step", 2'b01);
    wr(0, 24'h4);
    wr(1, 24'd2);
    step(0, 0, 0, "R7 idle", 2'b00);
    step(0, 0, 1, "R7 retire 1", 2'b00);
    step(0, 0, 0, "R7 idle", 2'b00);
    step(0, 0, 1, "R7 retire 2", 2'b01);
    wr(0, 24'h4);
    wr(1, 24'd0);
    step(0, 0, 1, "R6 zero count", 2'b00);
    step(0, 0, 1, "R6 zero count", 2'b00);
  endtask

  task automatic t_trigstart;
    wr(0, 24'h9);
    wr(1, 24'd2);
    step(0, 0, 1, "R8 retire before trigger", 2'b00);
    step(0, 0, 1, "R8 retire before trigger", 2'b00);
    step(1, 0, 1, "R8 trigger loads", 2'b00);
    step(0, 0, 1, "R8 count 1", 2'b00);
    step(0, 0, 1, "R8 expire", 2'b10);
  endtask

  task automatic t_wrblock;
    wr(0, 24'h1, 1'b1);
    chk("R11 match during write", {dbg_req, irq_req}, 2'b00);
    wr(0, 24'h4);
    wr(1, 24'd1);
    wr(0, 24'h4, 1'b0, 1'b1);
    chk("R11 retire during write", {dbg_req, irq_req}, 2'b00);
    wr(0, 24'h5);
    step(1, 0, 0, "R9 irq select", 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_or();
    t_and();
    t_seq();
    t_count();
    t_trigstart();
    t_wrblock();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule